// File: doc/BRIEF.md
# Three-Lane Register Renamer

The block sits between decode and scheduling. Each cycle it takes a group of up to three micro-ops, each with an optional architectural destination and two architectural sources. It hands back the physical registers those operands map to. Each destination gets a new physical register from a pool of 128, and each micro-op gets a slot in a circular reorder buffer. The slot records the architectural register, the new physical register and the one it replaced. The rename results are combinational in the cycle the group is offered, and the tables update at the next clock edge.

Two alias tables are kept. The speculative table follows every accepted rename. The retirement table is written only when the oldest reorder-buffer entry retires. Retirement copies no register value: it points the retirement table at the new physical register and returns the replaced register to the free list. A flush discards all speculative state. The speculative table becomes a copy of the retirement table, and the free list is rebuilt from every register the retirement table does not name. Register data, scheduling and execution live elsewhere.

Top module: `reg_renamer`

## Requirements
- R1: After reset, architectural register i (0 to 7) maps to physical register i, every other physical register is free, the reorder buffer is empty and the first index handed out is 0.
- R2: Each valid lane with a destination takes the lowest-numbered free physical register, with lane 0 served before lane 1 and lane 1 before lane 2. A lane without a destination reports 0 on `ren_dst_phys` and `ren_old_phys`.
- R3: Sources read the current speculative mapping, except that a source named as a destination by an older lane of the same group reads that lane's new register. `ren_old_phys` reports the mapping the destination replaced, and an older lane of the same group counts here too. A lane's own destination does not affect its own sources.
- R4: Valid lanes receive consecutive reorder-buffer indices in lane order, modulo 128, continuing from the previous accepted group. Invalid lanes consume no index.
- R5: `ren_accept` is 1 only when at least one lane is valid, the free registers number at least the destinations in the group, the free reorder-buffer slots number at least the valid lanes, and `flush` is 0. Otherwise the whole group is refused and no table, pointer or free register changes.
- R6: `ret_req` with a non-empty reorder buffer retires the oldest entry and drives `ret_fire` to 1. Retiring writes the entry's new register into the retirement table and frees its old register. With an empty buffer, or during a flush, `ret_req` is ignored and `ret_fire` is 0.
- R7: `flush` copies the retirement table into the speculative table, makes free exactly the registers the retirement table does not name, and empties the reorder buffer so that the next index is 0. A rename group or retire request in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 3 | Lane holds a micro-op |
| ren_has_dst | input | 3 | Lane writes a destination |
| ren_dst | input | 3x3 | Architectural destination per lane |
| ren_src_a | input | 3x3 | First architectural source per lane |
| ren_src_b | input | 3x3 | Second architectural source per lane |
| ren_accept | output | 1 | Group taken this cycle |
| ren_dst_phys | output | 3x7 | New physical destination per lane |
| ren_old_phys | output | 3x7 | Replaced physical register per lane |
| src_a_phys | output | 3x7 | Physical register for first source |
| src_b_phys | output | 3x7 | Physical register for second source |
| ren_rob_idx | output | 3x7 | Reorder-buffer index per lane |
| ret_req | input | 1 | Retire the oldest entry |
| ret_fire | output | 1 | A retirement took place |
| flush | input | 1 | Discard speculative state |

## Verification
Full groups that write one architectural register twice separate correct in-group forwarding from a plain table read. Sparse lane masks show whether invalid lanes consume reorder-buffer indices. Register exhaustion and reorder-buffer exhaustion are driven one step short of and one step past each limit, so an off-by-one in either room check shows up. Retiring, then flushing with a live rename group and retire request present, exposes the retirement table and rebuilt free list through the registers and indices the next group receives.

// File: rtl/rn_pkg.sv
package rn_pkg;
    localparam int ARCH_N = 8;
    localparam int PHYS_N = 128;
    localparam int LANES  = 3;
    localparam int ROB_N  = 128;
    localparam int AW     = $clog2(ARCH_N);
    localparam int PW     = $clog2(PHYS_N);
    localparam int RW     = $clog2(ROB_N);
    localparam int CW     = RW + 1;

    typedef logic [AW-1:0] areg_t;
    typedef logic [PW-1:0] preg_t;
    typedef logic [RW-1:0] rob_idx_t;
    typedef logic [CW-1:0] rob_cnt_t;

    typedef struct packed {
        logic  valid;
        logic  has_dst;
        areg_t dst;
        areg_t src_a;
        areg_t src_b;
    } uop_t;

    typedef struct packed {
        logic  has_dst;
        areg_t arch;
        preg_t new_p;
        preg_t old_p;
    } rob_ent_t;

    // Index of the least significant set bit, 0 when none is set.
    function automatic preg_t lowest_set(input logic [PHYS_N-1:0] v);
        preg_t r;
        r = '0;
        for (int i = PHYS_N - 1; i >= 0; i--) begin
            if (v[i]) r = preg_t'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist import rn_pkg::*; (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LANES-1:0]       need,
    input  logic                   take,
    input  logic                   give_en,
    input  preg_t                  give_p,
    input  logic                   rebuild,
    input  logic [PHYS_N-1:0]      rebuild_free,
    output preg_t [LANES-1:0]      pick,
    output logic                   enough
);
    localparam logic [PHYS_N-1:0] RESET_FREE = {PHYS_N{1'b1}} << ARCH_N;
    localparam logic [PHYS_N-1:0] ONE_HOT    = {{(PHYS_N-1){1'b0}}, 1'b1};

    logic [PHYS_N-1:0] free_q;
    logic [PHYS_N-1:0] taken;
    logic [PHYS_N-1:0] left;
    logic [PHYS_N-1:0] released;

    always_comb begin
        left  = free_q;
        taken = '0;
        for (int k = 0; k < LANES; k++) begin
            pick[k] = '0;
            if (need[k]) begin
                pick[k]        = lowest_set(left);
                left[pick[k]]  = 1'b0;
                taken[pick[k]] = 1'b1;
            end
        end
    end

    assign enough   = $countones(free_q) >= $countones(need);
    assign released = give_en ? (ONE_HOT << give_p) : '0;

    always_ff @(posedge clk) begin
        if (rst)          free_q <= RESET_FREE;
        else if (rebuild) free_q <= rebuild_free;
        else              free_q <= (take ? (free_q & ~taken) : free_q) | released;
    end

    // R6: a register handed back by retirement must not already be free
    p_no_double_free_r6: assert property (@(posedge clk) disable iff (rst)
        give_en |-> !free_q[give_p]);

    // R7: the rebuilt pool leaves exactly one register per architectural name in use
    p_rebuild_count_r7: assert property (@(posedge clk) disable iff (rst)
        rebuild |=> ($countones(free_q) == PHYS_N - ARCH_N));
endmodule

// File: rtl/rn_rob.sv
module rn_rob import rn_pkg::*; (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   push,
    input  logic [LANES-1:0]       lane_v,
    input  rob_ent_t [LANES-1:0]   lane_e,
    input  logic                   pop_req,
    input  logic                   clear,
    output rob_idx_t [LANES-1:0]   lane_idx,
    output logic                   room,
    output logic                   pop_fire,
    output rob_ent_t               head_e
);
    rob_ent_t mem_q [ROB_N];
    rob_idx_t head_q, tail_q, tail_end;
    rob_cnt_t count_q, n_push;

    always_comb begin
        tail_end = tail_q;
        n_push   = '0;
        for (int k = 0; k < LANES; k++) begin
            lane_idx[k] = tail_end;
            if (lane_v[k]) begin
                tail_end = tail_end + rob_idx_t'(1);
                n_push   = n_push + rob_cnt_t'(1);
            end
        end
    end

    assign room     = (int'(count_q) + int'(n_push)) <= ROB_N;
    assign pop_fire = pop_req && (count_q != '0) && !clear;
    assign head_e   = mem_q[head_q];

    always_ff @(posedge clk) begin
        if (push) begin
            for (int k = 0; k < LANES; k++) begin
                if (lane_v[k]) mem_q[lane_idx[k]] <= lane_e[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (push) tail_q <= tail_end;
            if (pop_fire) head_q <= head_q + rob_idx_t'(1);
            count_q <= count_q + (push ? n_push : rob_cnt_t'(0))
                               - rob_cnt_t'(pop_fire);
        end
    end

    // R5: occupancy never exceeds the buffer depth
    p_rob_bound_r5: assert property (@(posedge clk) disable iff (rst)
        count_q <= rob_cnt_t'(ROB_N));

    // R7: a flush leaves the buffer empty
    p_clear_empties_r7: assert property (@(posedge clk) disable iff (rst)
        clear |=> (count_q == '0));
endmodule

// File: rtl/rn_maps.sv
module rn_maps import rn_pkg::*; (
    input  logic                   clk,
    input  logic                   rst,
    input  uop_t [LANES-1:0]       uops,
    input  preg_t [LANES-1:0]      new_p,
    input  logic                   commit,
    input  logic                   ret_en,
    input  areg_t                  ret_arch,
    input  preg_t                  ret_p,
    input  logic                   restore,
    output preg_t [LANES-1:0]      src_a_p,
    output preg_t [LANES-1:0]      src_b_p,
    output preg_t [LANES-1:0]      old_p,
    output logic [PHYS_N-1:0]      unref
);
    preg_t srat_q [ARCH_N];
    preg_t rrat_q [ARCH_N];
    preg_t srat_d [ARCH_N];

    // Lanes walk in age order so younger lanes see older destinations.
    always_comb begin
        srat_d = srat_q;
        for (int k = 0; k < LANES; k++) begin
            src_a_p[k] = srat_d[uops[k].src_a];
            src_b_p[k] = srat_d[uops[k].src_b];
            old_p[k]   = '0;
            if (uops[k].valid && uops[k].has_dst) begin
                old_p[k]             = srat_d[uops[k].dst];
                srat_d[uops[k].dst]  = new_p[k];
            end
        end
    end

    always_comb begin
        unref = '1;
        for (int a = 0; a < ARCH_N; a++) unref[rrat_q[a]] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < ARCH_N; a++) begin
                srat_q[a] <= preg_t'(a);
                rrat_q[a] <= preg_t'(a);
            end
        end else if (restore) begin
            srat_q <= rrat_q;
        end else begin
            if (commit) srat_q <= srat_d;
            if (ret_en) rrat_q[ret_arch] <= ret_p;
        end
    end

    // R7: after a flush every speculative entry equals the retirement entry
    for (genvar a = 0; a < ARCH_N; a++) begin : g_restore_chk
        p_restore_map_r7: assert property (@(posedge clk) disable iff (rst)
            restore |=> (srat_q[a] == $past(rrat_q[a])));
    end
endmodule

// File: rtl/reg_renamer.sv
module reg_renamer import rn_pkg::*; (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [LANES-1:0]            ren_valid,
    input  logic [LANES-1:0]            ren_has_dst,
    input  logic [LANES-1:0][AW-1:0]    ren_dst,
    input  logic [LANES-1:0][AW-1:0]    ren_src_a,
    input  logic [LANES-1:0][AW-1:0]    ren_src_b,
    output logic                        ren_accept,
    output logic [LANES-1:0][PW-1:0]    ren_dst_phys,
    output logic [LANES-1:0][PW-1:0]    ren_old_phys,
    output logic [LANES-1:0][PW-1:0]    src_a_phys,
    output logic [LANES-1:0][PW-1:0]    src_b_phys,
    output logic [LANES-1:0][RW-1:0]    ren_rob_idx,
    input  logic                        ret_req,
    output logic                        ret_fire,
    input  logic                        flush
);
    uop_t     [LANES-1:0] uops;
    rob_ent_t [LANES-1:0] ents;
    preg_t    [LANES-1:0] pick, old_p, sa_p, sb_p;
    rob_idx_t [LANES-1:0] idx;
    logic     [LANES-1:0] need;
    logic [PHYS_N-1:0]    unref;
    logic                 regs_ok, rob_ok, give;
    rob_ent_t             head_e;

    assign need = ren_valid & ren_has_dst;

    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            uops[k] = '{valid: ren_valid[k], has_dst: ren_has_dst[k],
                        dst: ren_dst[k], src_a: ren_src_a[k], src_b: ren_src_b[k]};
            ents[k] = '{has_dst: need[k], arch: ren_dst[k],
                        new_p: pick[k], old_p: old_p[k]};
        end
    end

    assign ren_accept = (|ren_valid) && regs_ok && rob_ok && !flush;
    assign give       = ret_fire && head_e.has_dst;

    rn_freelist u_free (
        .clk(clk), .rst(rst), .need(need), .take(ren_accept),
        .give_en(give), .give_p(head_e.old_p),
        .rebuild(flush), .rebuild_free(unref),
        .pick(pick), .enough(regs_ok)
    );

    rn_maps u_maps (
        .clk(clk), .rst(rst), .uops(uops), .new_p(pick), .commit(ren_accept),
        .ret_en(give), .ret_arch(head_e.arch), .ret_p(head_e.new_p),
        .restore(flush), .src_a_p(sa_p), .src_b_p(sb_p), .old_p(old_p),
        .unref(unref)
    );

    rn_rob u_rob (
        .clk(clk), .rst(rst), .push(ren_accept), .lane_v(ren_valid),
        .lane_e(ents), .pop_req(ret_req), .clear(flush),
        .lane_idx(idx), .room(rob_ok), .pop_fire(ret_fire), .head_e(head_e)
    );

    assign ren_dst_phys = pick;
    assign ren_old_phys = old_p;
    assign src_a_phys   = sa_p;
    assign src_b_phys   = sb_p;
    assign ren_rob_idx  = idx;
endmodule

// File: tb/reg_renamer_tb_top.sv
module reg_renamer_tb_top;
    import rn_pkg::*;

    typedef struct packed {
        logic [2:0]      v;
        logic [2:0]      hd;
        logic [2:0][2:0] d;
        logic [2:0][2:0] sa;
        logic [2:0][2:0] sb;
        logic            acc;
        logic [2:0][6:0] e_dst;
        logic [2:0][6:0] e_sa;
        logic [2:0][6:0] e_sb;
        logic [2:0][6:0] e_old;
        logic [2:0][6:0] e_rob;
    } vec_t;

    // Lane fields are written {lane2, lane1, lane0}; run in order from reset.
    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{3'b111, 3'b111, {3'd1,3'd2,3'd1}, {3'd2,3'd1,3'd1}, {3'd1,3'd0,3'd3}, 1'b1,
          {7'd10,7'd9,7'd8}, {7'd9,7'd8,7'd1}, {7'd8,7'd0,7'd3}, {7'd8,7'd2,7'd1}, {7'd2,7'd1,7'd0}},
        '{3'b101, 3'b100, {3'd7,3'd0,3'd0}, {3'd1,3'd0,3'd1}, {3'd7,3'd0,3'd2}, 1'b1,
          {7'd11,7'd0,7'd0}, {7'd10,7'd0,7'd10}, {7'd7,7'd0,7'd9}, {7'd7,7'd0,7'd0}, {7'd4,7'd0,7'd3}},
        '{3'b100, 3'b100, {3'd3,3'd0,3'd0}, {3'd7,3'd0,3'd0}, {3'd3,3'd0,3'd0}, 1'b1,
          {7'd12,7'd0,7'd0}, {7'd11,7'd0,7'd0}, {7'd3,7'd0,7'd0}, {7'd3,7'd0,7'd0}, {7'd5,7'd0,7'd0}},
        '{3'b000, 3'b000, {3'd0,3'd0,3'd0}, {3'd0,3'd0,3'd0}, {3'd0,3'd0,3'd0}, 1'b0,
          {7'd0,7'd0,7'd0}, {7'd0,7'd0,7'd0}, {7'd0,7'd0,7'd0}, {7'd0,7'd0,7'd0}, {7'd0,7'd0,7'd0}},
        '{3'b011, 3'b011, {3'd0,3'd3,3'd3}, {3'd0,3'd3,3'd3}, {3'd0,3'd2,3'd1}, 1'b1,
          {7'd0,7'd14,7'd13}, {7'd0,7'd13,7'd12}, {7'd0,7'd9,7'd10}, {7'd0,7'd13,7'd12}, {7'd0,7'd7,7'd6}}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] ren_valid = '0, ren_has_dst = '0;
    logic [2:0][2:0] ren_dst = '0, ren_src_a = '0, ren_src_b = '0;
    logic ren_accept, ret_req = 1'b0, ret_fire, flush = 1'b0;
    logic [2:0][6:0] ren_dst_phys, ren_old_phys, src_a_phys, src_b_phys, ren_rob_idx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    reg_renamer dut_i (
        .clk(clk), .rst(rst), .ren_valid(ren_valid), .ren_has_dst(ren_has_dst),
        .ren_dst(ren_dst), .ren_src_a(ren_src_a), .ren_src_b(ren_src_b),
        .ren_accept(ren_accept), .ren_dst_phys(ren_dst_phys), .ren_old_phys(ren_old_phys),
        .src_a_phys(src_a_phys), .src_b_phys(src_b_phys), .ren_rob_idx(ren_rob_idx),
        .ret_req(ret_req), .ret_fire(ret_fire), .flush(flush)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Apply a group at a falling edge; outputs are read 5 ns later, before the commit edge.
    task automatic drive(input logic [2:0] v, input logic [2:0] hd, input logic [2:0][2:0] d,
                         input logic [2:0][2:0] sa, input logic [2:0][2:0] sb,
                         input logic rr, input logic fl);
        @(negedge clk);
        ren_valid = v; ren_has_dst = hd; ren_dst = d;
        ren_src_a = sa; ren_src_b = sb; ret_req = rr; flush = fl;
        #5;
    endtask

    task automatic retire(input int exp_fire);
        drive(3'b000, 3'b000, '0, '0, '0, 1'b1, 1'b0);
        chk("R6", int'(ret_fire), exp_fire);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: empty buffer after reset, retire request ignored
        retire(0);

        // Vector table: R1 (reset map), R2, R3, R4, R5
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].v, VECS[i].hd, VECS[i].d, VECS[i].sa, VECS[i].sb, 1'b0, 1'b0);
            chk("R5", int'(ren_accept), int'(VECS[i].acc));
            for (int k = 0; k < 3; k++) begin
                if (VECS[i].v[k]) begin
                    chk("R2", int'(ren_dst_phys[k]), int'(VECS[i].e_dst[k]));
                    chk(i == 0 ? "R1" : "R3", int'(src_a_phys[k]), int'(VECS[i].e_sa[k]));
                    chk(i == 0 ? "R1" : "R3", int'(src_b_phys[k]), int'(VECS[i].e_sb[k]));
                    chk("R3", int'(ren_old_phys[k]), int'(VECS[i].e_old[k]));
                    chk("R4", int'(ren_rob_idx[k]), int'(VECS[i].e_rob[k]));
                end
            end
        end

        // R6: retire oldest (r1: 1 -> 8) frees physical 1, which is lowest free
        retire(1);
        drive(3'b001, 3'b001, {3'd0,3'd0,3'd0}, '0, '0, 1'b0, 1'b0);
        chk("R6", int'(ren_dst_phys[0]), 1);
        chk("R4", int'(ren_rob_idx[0]), 8);
        retire(1);
        retire(1);

        // R7: flush with a live group and a retire request; both ignored
        drive(3'b111, 3'b111, {3'd4,3'd5,3'd6}, '0, '0, 1'b1, 1'b1);
        chk("R7", int'(ren_accept), 0);
        chk("R7", int'(ret_fire), 0);
        retire(0);

        // Retirement table now r1->10, r2->9, rest identity; free lowest are 1, 2, 8
        drive(3'b111, 3'b111, {3'd6,3'd5,3'd0}, {3'd0,3'd3,3'd1}, {3'd4,3'd7,3'd2}, 1'b0, 1'b0);
        chk("R7", int'(ren_accept), 1);
        chk("R7", int'(src_a_phys[0]), 10);
        chk("R7", int'(src_b_phys[0]), 9);
        chk("R7", int'(src_a_phys[1]), 3);
        chk("R7", int'(ren_old_phys[1]), 5);
        chk("R7", int'(src_a_phys[2]), 1);
        chk("R7", int'(ren_dst_phys[0]), 1);
        chk("R7", int'(ren_dst_phys[1]), 2);
        chk("R7", int'(ren_dst_phys[2]), 8);
        chk("R7", int'(ren_rob_idx[0]), 0);

        // Drain the 117 remaining free registers, three per group
        for (int g = 0; g < 39; g++) begin
            drive(3'b111, 3'b111, {3'd3,3'd2,3'd1}, {3'd0,3'd1,3'd0}, '0, 1'b0, 1'b0);
            chk("R5", int'(ren_accept), 1);
            chk("R2", int'(ren_dst_phys[2]), 13 + 3 * g);
            chk("R3", int'(src_a_phys[1]), 11 + 3 * g);
            chk("R4", int'(ren_rob_idx[2]), 5 + 3 * g);
        end

        // R5: no register left, one destination refused
        drive(3'b001, 3'b001, '0, '0, '0, 1'b0, 1'b0);
        chk("R5", int'(ren_accept), 0);
        drive(3'b111, 3'b000, '0, '0, '0, 1'b0, 1'b0);
        chk("R5", int'(ren_accept), 1);
        chk("R5", int'(ren_rob_idx[0]), 120);
        drive(3'b111, 3'b000, '0, '0, '0, 1'b0, 1'b0);
        chk("R5", int'(ren_accept), 1);
        // 126 used: three more would overflow
        drive(3'b111, 3'b000, '0, '0, '0, 1'b0, 1'b0);
        chk("R5", int'(ren_accept), 0);
        drive(3'b011, 3'b000, '0, '0, '0, 1'b0, 1'b0);
        chk("R5", int'(ren_accept), 1);
        chk("R4", int'(ren_rob_idx[1]), 127);
        drive(3'b001, 3'b000, '0, '0, '0, 1'b0, 1'b0);
        chk("R5", int'(ren_accept), 0);

        // R4 wrap: retiring index 0 frees physical 0 and slot 0
        retire(1);
        drive(3'b001, 3'b001, {3'd0,3'd0,3'd4}, '0, '0, 1'b0, 1'b0);
        chk("R5", int'(ren_accept), 1);
        chk("R2", int'(ren_dst_phys[0]), 0);
        chk("R4", int'(ren_rob_idx[0]), 0);
        drive('0, '0, '0, '0, '0, 1'b0, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule